// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM

A 4,096-bit synchronous storage block whose depth×width shape is chosen by static configuration inputs. In the common case port A is the write port and port B is the read port. The two ports can run at one shared width, or, in mixed mode, one port is a single bit wide while the other is 2, 4, 8 or 16 bits wide, and both views cover the same bits. In split mode the array becomes two independent 2,048-bit single-port RAMs. The pins of port A serve the lower half and the pins of port B serve the upper half.

Every write is taken on the rising clock edge, and the block gates its own write strobe. The user only meets setup and hold times against that edge. A small configuration controller samples the configuration and checks that it is legal. Storage is opened only while the latched configuration is valid. The controller has three states. CHECK latches and judges the configuration. RUN allows access. REJECT signals an illegal request. The transitions are: reset→CHECK; CHECK→RUN (legal); CHECK→REJECT (illegal); RUN→CHECK (configuration inputs differ from the latched copy); REJECT→CHECK (same condition).

Top module: `cmw_ram`

## Requirements
- R1: In mode 0 (uniform), both width codes must be equal and in the range 0..4, where code k means a width of 2^k bits and a depth of 4096/2^k. A word written on port A at an address is returned on port B at that address.
- R2: In mode 1 (mixed), one width code must be 0 and the other 1..4. Mapping is little-endian. Wide word w of width W covers narrow addresses w·W to w·W+W−1, and narrow address w·W is wide-word bit 0.
- R3: In mode 2 (split), both codes must be equal and in the range 0..3. Port A pins (a_addr, a_wdata, a_we, a_re, a_rdata) access bits 0..2047. Port B pins (b_addr, b_wdata, b_we, b_re, b_rdata) access bits 2048..4095. The two halves never affect each other.
- R4: Mode 3 and every configuration that breaks R1–R3 drive cfg_err high and cfg_ok low, and the controller stays in REJECT while the inputs are unchanged. Without cfg_ok there are no writes and no read updates.
- R5: Read data appears on the output one clock after the read enable is sampled. A read and a write to the same location in one cycle return the old data.
- R6: Address bits above the depth of the current shape are ignored. In split mode the depth is that of a half.
- R7: While a port's read enable is low, its read data output holds its value.
- R8: While a port's write enable is low, that port writes nothing.
- R9: During reset, cfg_ok, cfg_err, a_rdata and b_rdata are 0. The first cycle after reset is spent in CHECK, and a legal configuration reaches RUN on the next edge.
- R10: A change of any configuration input while in RUN drops cfg_ok on the next edge. The controller passes through CHECK (cfg_ok and cfg_err both low) before reaching RUN or REJECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all timing taken from its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | 0 uniform, 1 mixed, 2 split, 3 reserved |
| cfg_wa | input | 3 | Port A width code (width 2^code) |
| cfg_wb | input | 3 | Port B width code (width 2^code) |
| cfg_ok | output | 1 | Configuration accepted, storage open |
| cfg_err | output | 1 | Configuration rejected |
| a_addr | input | 12 | Port A address |
| a_wdata | input | 16 | Port A write data, low bits used |
| a_we | input | 1 | Port A write enable |
| a_re | input | 1 | Port A read enable (split mode only) |
| a_rdata | output | 16 | Port A read data (split mode, lower half) |
| b_addr | input | 12 | Port B address |
| b_wdata | input | 16 | Port B write data (split mode only) |
| b_we | input | 1 | Port B write enable (split mode only) |
| b_re | input | 1 | Port B read enable |
| b_rdata | output | 16 | Port B read data, zero-extended |

## Verification
Storage is first filled through the 16-bit uniform shape. Each of the five uniform shapes is then written and read at scattered addresses, which separates correct address scaling from lane placement errors. Mixed mode is exercised in both directions. Bit-by-bit narrow writes read back as a wide word, and wide writes read back as narrow bits, which exposes any reversal of the little-endian order. Split mode writes different data to the same address in both halves during the same cycle, which shows whether the halves are isolated. A table of legal and illegal configurations exercises the controller, and directed cases cover same-cycle read/write, high address bits, held enables and a configuration change in RUN.

// File: rtl/cmw_pkg.sv
package cmw_pkg;

    localparam int LW_BITS = 3;

    typedef enum logic [1:0] {
        MODE_SAME  = 2'd0,
        MODE_MIXED = 2'd1,
        MODE_SPLIT = 2'd2,
        MODE_RSVD  = 2'd3
    } cmw_mode_e;

    typedef enum logic [1:0] {
        ST_CHECK  = 2'd0,
        ST_RUN    = 2'd1,
        ST_REJECT = 2'd2
    } cmw_state_e;

    typedef struct packed {
        logic [1:0]         mode;
        logic [LW_BITS-1:0] lwa;
        logic [LW_BITS-1:0] lwb;
    } cmw_cfg_t;

    // lw_max is log2 of the full word width; split halves stop one code below it.
    function automatic logic cfg_legal(cmw_cfg_t c, logic [LW_BITS-1:0] lw_max);
        logic ok;
        ok = 1'b0;
        unique case (c.mode)
            MODE_SAME:  ok = (c.lwa == c.lwb) && (c.lwa <= lw_max);
            MODE_MIXED: ok = ((c.lwa == '0) && (c.lwb != '0) && (c.lwb <= lw_max)) ||
                             ((c.lwb == '0) && (c.lwa != '0) && (c.lwa <= lw_max));
            MODE_SPLIT: ok = (c.lwa == c.lwb) && (c.lwa < lw_max);
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/cmw_cfg_fsm.sv
module cmw_cfg_fsm
    import cmw_pkg::*;
#(
    parameter logic [LW_BITS-1:0] LW_MAX = 3'd4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmw_cfg_t cfg_in,
    output cmw_cfg_t cfg_q,
    output logic     run,
    output logic     cfg_ok,
    output logic     cfg_err
);

    cmw_state_e state_q;
    cmw_state_e state_d;
    cmw_cfg_t   snap_q;

    // State register with the configuration snapshot taken in CHECK.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CHECK;
            snap_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CHECK) begin
                snap_q <= cfg_in;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CHECK:  state_d = cfg_legal(cfg_in, LW_MAX) ? ST_RUN : ST_REJECT;
            ST_RUN:    if (cfg_in != snap_q) state_d = ST_CHECK;
            ST_REJECT: if (cfg_in != snap_q) state_d = ST_CHECK;
            default:   state_d = ST_CHECK;
        endcase
    end

    always_comb begin
        run     = 1'b0;
        cfg_ok  = 1'b0;
        cfg_err = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                run    = 1'b1;
                cfg_ok = 1'b1;
            end
            ST_REJECT: cfg_err = 1'b1;
            default: ;
        endcase
    end

    assign cfg_q = snap_q;

endmodule

// File: rtl/cmw_addr_map.sv
module cmw_addr_map
    import cmw_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = 16,
    localparam int LANE_W = $clog2(WORD_W),
    localparam int IDX_W  = ADDR_W - LANE_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LW_BITS-1:0] lw,
    input  logic               split,
    input  logic               half,
    output logic [IDX_W-1:0]   idx,
    output logic [LANE_W-1:0]  lane,
    output logic [WORD_W-1:0]  wmask
);

    logic [ADDR_W-1:0] keep;
    logic [ADDR_W-1:0] bitpos;

    always_comb begin
        // Depth in words is 2^(ADDR_W - lw), halved again in split mode.
        keep   = ({ADDR_W{1'b1}} >> lw) >> split;
        bitpos = (addr & keep) << lw;
        if (half) begin
            bitpos[ADDR_W-1] = 1'b1;
        end
        idx  = bitpos[ADDR_W-1 -: IDX_W];
        lane = bitpos[LANE_W-1:0];
        for (int i = 0; i < WORD_W; i++) begin
            wmask[i] = ((i >> lw) == 0);
        end
    end

endmodule

// File: rtl/cmw_array.sv
module cmw_array #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 256,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int LANE_W = $clog2(WORD_W),
    localparam int NPORT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en   [NPORT],
    input  logic [IDX_W-1:0]  wr_idx  [NPORT],
    input  logic [LANE_W-1:0] wr_lane [NPORT],
    input  logic [WORD_W-1:0] wr_mask [NPORT],
    input  logic [WORD_W-1:0] wr_data [NPORT],
    input  logic              rd_en   [NPORT],
    input  logic [IDX_W-1:0]  rd_idx  [NPORT],
    input  logic [LANE_W-1:0] rd_lane [NPORT],
    input  logic [WORD_W-1:0] rd_mask [NPORT],
    output logic [WORD_W-1:0] rd_data [NPORT]
);

    logic [WORD_W-1:0] mem [DEPTH];

    // Internal write strobe: a lane-masked merge on the clock edge.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NPORT; p++) begin
            if (wr_en[p]) begin
                mem[wr_idx[p]] <= (mem[wr_idx[p]] & ~(wr_mask[p] << wr_lane[p])) |
                                  ((wr_data[p] & wr_mask[p]) << wr_lane[p]);
            end
        end
    end

    // Registered reads see the array before this edge's writes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORT; p++) begin
                rd_data[p] <= '0;
            end
        end else begin
            for (int p = 0; p < NPORT; p++) begin
                if (rd_en[p]) begin
                    rd_data[p] <= (mem[rd_idx[p]] >> rd_lane[p]) & rd_mask[p];
                end
            end
        end
    end

endmodule

// File: rtl/cmw_ram.sv
module cmw_ram
    import cmw_pkg::*;
#(
    parameter int TOTAL_BITS = 4096,
    parameter int WORD_W     = 16,
    localparam int ADDR_W = $clog2(TOTAL_BITS),
    localparam int LANE_W = $clog2(WORD_W),
    localparam int IDX_W  = ADDR_W - LANE_W,
    localparam int DEPTH  = TOTAL_BITS / WORD_W,
    localparam logic [LW_BITS-1:0] LW_MAX = LW_BITS'(LANE_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         cfg_mode,
    input  logic [LW_BITS-1:0] cfg_wa,
    input  logic [LW_BITS-1:0] cfg_wb,
    output logic               cfg_ok,
    output logic               cfg_err,
    input  logic [ADDR_W-1:0]  a_addr,
    input  logic [WORD_W-1:0]  a_wdata,
    input  logic               a_we,
    input  logic               a_re,
    output logic [WORD_W-1:0]  a_rdata,
    input  logic [ADDR_W-1:0]  b_addr,
    input  logic [WORD_W-1:0]  b_wdata,
    input  logic               b_we,
    input  logic               b_re,
    output logic [WORD_W-1:0]  b_rdata
);

    cmw_cfg_t cfg_in;
    cmw_cfg_t cfg_q;
    logic     run;
    logic     is_split;

    assign cfg_in = '{mode: cfg_mode, lwa: cfg_wa, lwb: cfg_wb};

    cmw_cfg_fsm #(.LW_MAX(LW_MAX)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (cfg_in),
        .cfg_q   (cfg_q),
        .run     (run),
        .cfg_ok  (cfg_ok),
        .cfg_err (cfg_err)
    );

    assign is_split = (cfg_q.mode == MODE_SPLIT);

    logic [ADDR_W-1:0]  p_addr [2];
    logic [LW_BITS-1:0] p_lw   [2];
    logic               p_half [2];
    logic [IDX_W-1:0]   p_idx  [2];
    logic [LANE_W-1:0]  p_lane [2];
    logic [WORD_W-1:0]  p_mask [2];
    logic               wr_en  [2];
    logic [WORD_W-1:0]  wr_dat [2];
    logic               rd_en  [2];
    logic [WORD_W-1:0]  rd_dat [2];

    // Port A: lower half in split mode; port B: upper half in split mode.
    assign p_addr[0] = a_addr;
    assign p_addr[1] = b_addr;
    assign p_lw[0]   = cfg_q.lwa;
    assign p_lw[1]   = is_split ? cfg_q.lwa : cfg_q.lwb;
    assign p_half[0] = 1'b0;
    assign p_half[1] = is_split;

    for (genvar p = 0; p < 2; p++) begin : g_port
        cmw_addr_map #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_map (
            .addr  (p_addr[p]),
            .lw    (p_lw[p]),
            .split (is_split),
            .half  (p_half[p]),
            .idx   (p_idx[p]),
            .lane  (p_lane[p]),
            .wmask (p_mask[p])
        );
    end

    assign wr_en[0]  = run && a_we;
    assign wr_en[1]  = run && is_split && b_we;
    assign rd_en[0]  = run && is_split && a_re;
    assign rd_en[1]  = run && b_re;
    assign wr_dat[0] = a_wdata;
    assign wr_dat[1] = b_wdata;

    cmw_array #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (p_idx),
        .wr_lane (p_lane),
        .wr_mask (p_mask),
        .wr_data (wr_dat),
        .rd_en   (rd_en),
        .rd_idx  (p_idx),
        .rd_lane (p_lane),
        .rd_mask (p_mask),
        .rd_data (rd_dat)
    );

    assign a_rdata = rd_dat[0];
    assign b_rdata = rd_dat[1];

endmodule

// File: rtl/cmw_ram_chk.sv
module cmw_ram_chk #(
    parameter int AW = 12,
    parameter int DW = 16,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    cfg_mode,
    input logic [CW-1:0] cfg_wa,
    input logic [CW-1:0] cfg_wb,
    input logic          cfg_ok,
    input logic          cfg_err,
    input logic          a_re,
    input logic          b_re,
    input logic [DW-1:0] a_rdata,
    input logic [DW-1:0] b_rdata
);

    AST_CLOSED_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ok |=> ($stable(a_rdata) && $stable(b_rdata))); // R4

    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && $stable({cfg_mode, cfg_wa, cfg_wb})) |=> cfg_err); // R4

    AST_HOLD_A_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !a_re |=> $stable(a_rdata)); // R7

    AST_HOLD_B_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        !b_re |=> $stable(b_rdata)); // R7

    AST_RECHECK_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ok && ({cfg_mode, cfg_wa, cfg_wb} != $past({cfg_mode, cfg_wa, cfg_wb})))
        |=> !cfg_ok); // R10

endmodule

bind cmw_ram cmw_ram_chk #(.AW(ADDR_W), .DW(WORD_W), .CW(cmw_pkg::LW_BITS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .cfg_wa   (cfg_wa),
    .cfg_wb   (cfg_wb),
    .cfg_ok   (cfg_ok),
    .cfg_err  (cfg_err),
    .a_re     (a_re),
    .b_re     (b_re),
    .a_rdata  (a_rdata),
    .b_rdata  (b_rdata)
);

// File: tb/tb_cmw_ram.sv
module tb_cmw_ram;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_mode;
    logic [2:0]  cfg_wa, cfg_wb;
    logic        cfg_ok, cfg_err;
    logic [11:0] a_addr, b_addr;
    logic [15:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic        a_we, a_re, b_we, b_re;

    always #5 clk = ~clk; // 10 ns period, 100 MHz

    cmw_ram dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_mode(cfg_mode), .cfg_wa(cfg_wa), .cfg_wb(cfg_wb),
        .cfg_ok(cfg_ok), .cfg_err(cfg_err),
        .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_re(a_re), .a_rdata(a_rdata),
        .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_re(b_re), .b_rdata(b_rdata)
    );

    int checks = 0;
    int errors = 0;
    logic [4095:0] ref_bits;
    logic [15:0]   exp_a, exp_b;
    int cur_mode, cur_wa, cur_wb;
    bit cur_legal;

    // {mode[1:0], wa[2:0], wb[2:0], legal}
    localparam logic [8:0] CFG_TAB [16] = '{
        {2'd0, 3'd0, 3'd0, 1'b1}, {2'd0, 3'd2, 3'd2, 1'b1}, {2'd0, 3'd4, 3'd4, 1'b1},
        {2'd0, 3'd5, 3'd5, 1'b0}, {2'd0, 3'd1, 3'd2, 1'b0}, {2'd1, 3'd0, 3'd1, 1'b1},
        {2'd1, 3'd0, 3'd4, 1'b1}, {2'd1, 3'd3, 3'd0, 1'b1}, {2'd1, 3'd0, 3'd0, 1'b0},
        {2'd1, 3'd2, 3'd3, 1'b0}, {2'd1, 3'd0, 3'd5, 1'b0}, {2'd2, 3'd0, 3'd0, 1'b1},
        {2'd2, 3'd3, 3'd3, 1'b1}, {2'd2, 3'd4, 3'd4, 1'b0}, {2'd2, 3'd1, 3'd2, 1'b0},
        {2'd3, 3'd0, 3'd0, 1'b0}
    };

    task automatic chk16(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int fbase(int addr, int lw, bit split, bit half);
        int kb;
        kb = 12 - lw - int'(split);
        return (half ? 2048 : 0) + ((addr % (1 << kb)) << lw);
    endfunction

    function automatic logic [15:0] gather(int base, int lw);
        logic [15:0] r;
        r = '0;
        for (int i = 0; i < (1 << lw); i++) r[i] = ref_bits[base + i];
        return r;
    endfunction

    task automatic scatter(int base, int lw, logic [15:0] d);
        for (int i = 0; i < (1 << lw); i++) ref_bits[base + i] = d[i];
    endtask

    task automatic set_cfg(int m, int wa, int wb, bit lg);
        cfg_mode = 2'(m); cfg_wa = 3'(wa); cfg_wb = 3'(wb);
        cur_mode = m; cur_wa = wa; cur_wb = wb; cur_legal = lg;
        repeat (3) @(negedge clk);
    endtask

    // One access cycle, called and returning at a falling edge.
    task automatic op(bit awe, int aa, logic [15:0] awd, bit are,
                      bit bwe, int ba, logic [15:0] bwd, bit bre, string req);
        bit sp;
        int lb;
        sp = (cur_mode == 2);
        lb = sp ? cur_wa : cur_wb;
        if (cur_legal && bre) exp_b = gather(fbase(ba, lb, sp, sp), lb);
        if (cur_legal && sp && are) exp_a = gather(fbase(aa, cur_wa, 1'b1, 1'b0), cur_wa);
        if (cur_legal && awe) scatter(fbase(aa, cur_wa, sp, 1'b0), cur_wa, awd);
        if (cur_legal && sp && bwe) scatter(fbase(ba, cur_wa, 1'b1, 1'b1), cur_wa, bwd);
        a_we = awe; a_addr = 12'(aa); a_wdata = awd; a_re = are;
        b_we = bwe; b_addr = 12'(ba); b_wdata = bwd; b_re = bre;
        @(negedge clk);
        a_we = 1'b0; a_re = 1'b0; b_we = 1'b0; b_re = 1'b0;
        chk16(req, "a_rdata", a_rdata, exp_a);
        chk16(req, "b_rdata", b_rdata, exp_b);
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_we = 0; a_re = 0; b_we = 0; b_re = 0;
        a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
        cfg_mode = 2'd0; cfg_wa = 3'd4; cfg_wb = 3'd4;
        cur_mode = 0; cur_wa = 4; cur_wb = 4; cur_legal = 1'b1;
        exp_a = '0; exp_b = '0;
        ref_bits = '0;
        repeat (3) @(negedge clk);
        // R9: reset values
        chk16("R9", "cfg_ok in reset", 16'(cfg_ok), 16'd0);
        chk16("R9", "cfg_err in reset", 16'(cfg_err), 16'd0);
        chk16("R9", "a_rdata in reset", a_rdata, 16'd0);
        chk16("R9", "b_rdata in reset", b_rdata, 16'd0);
        rst_n = 1'b1;
        chk16("R9", "cfg_ok before first edge", 16'(cfg_ok), 16'd0);
        @(negedge clk);
        chk16("R9", "cfg_ok after CHECK", 16'(cfg_ok), 16'd1);

        // R1: fill every word through the 256x16 shape, then spot-read
        for (int w = 0; w < 256; w++) op(1, w, 16'(w * 40503 + 7), 0, 0, 0, 0, 0, "R1");
        for (int w = 0; w < 256; w += 37) op(0, 0, 0, 0, 0, w, 0, 1, "R1");

        // R4: legality table walk
        for (int t = 0; t < 16; t++) begin
            set_cfg(int'(CFG_TAB[t][8:7]), int'(CFG_TAB[t][6:4]), int'(CFG_TAB[t][3:1]), CFG_TAB[t][0]);
            chk16("R4", "cfg_ok", 16'(cfg_ok), 16'(CFG_TAB[t][0]));
            chk16("R4", "cfg_err", 16'(cfg_err), 16'(!CFG_TAB[t][0]));
        end
        // R4: no write or read while rejected (mode 3 is current)
        op(1, 5, 16'hDEAD, 0, 0, 5, 0, 1, "R4");
        set_cfg(0, 4, 4, 1'b1);
        op(0, 0, 0, 0, 0, 5, 0, 1, "R4");
        chk16("R4", "word 5 untouched", b_rdata, 16'(5 * 40503 + 7));

        // R1 and R5: every uniform shape
        for (int k = 0; k <= 4; k++) begin
            set_cfg(0, k, k, 1'b1);
            for (int j = 0; j < 6; j++) begin
                op(1, j * 37 + k * 11, 16'(j * 16'h1357) ^ 16'(k), 0, 0, 0, 0, 0, "R1");
                op(0, 0, 0, 0, 0, j * 37 + k * 11, 0, 1, "R1");
            end
            op(1, 100 + k, 16'hBEEF, 0, 0, 100 + k, 0, 1, "R5");
            op(0, 0, 0, 0, 0, 100 + k, 0, 1, "R5");
        end

        // R2: narrow write, wide read
        for (int k = 1; k <= 4; k++) begin
            set_cfg(1, 0, k, 1'b1);
            for (int j = 0; j < (1 << k); j++)
                op(1, (3 + k) * (1 << k) + j, 16'((j * 5 + k) & 1), 0, 0, 0, 0, 0, "R2");
            op(0, 0, 0, 0, 0, 3 + k, 0, 1, "R2");
        end
        set_cfg(1, 0, 3, 1'b1);
        for (int j = 0; j < 8; j++) op(1, 16 + j, 16'(j == 0), 0, 0, 0, 0, 0, "R2");
        op(0, 0, 0, 0, 0, 2, 0, 1, "R2");
        chk16("R2", "narrow addr 16 is wide bit 0", b_rdata, 16'h0001);
        // R2: wide write, narrow read
        for (int k = 1; k <= 4; k++) begin
            set_cfg(1, k, 0, 1'b1);
            op(1, 2, 16'hA5C3, 0, 0, 0, 0, 0, "R2");
            for (int j = 0; j < (1 << k); j++) op(0, 0, 0, 0, 0, 2 * (1 << k) + j, 0, 1, "R2");
        end

        // R3: split halves isolated
        for (int k = 0; k <= 3; k++) begin
            set_cfg(2, k, k, 1'b1);
            for (int j = 0; j < 4; j++) begin
                op(1, j * 5 + 1, 16'(16'h1111 * (j + 1)), 0, 1, j * 5 + 1, ~16'(16'h1111 * (j + 1)), 0, "R3");
                op(0, j * 5 + 1, 0, 1, 0, j * 5 + 1, 0, 1, "R3");
            end
        end
        set_cfg(0, 4, 4, 1'b1);
        op(0, 0, 0, 0, 0, 0, 0, 1, "R3");
        op(0, 0, 0, 0, 0, 128, 0, 1, "R3");

        // R6: high address bits ignored (512x8, 9 address bits)
        set_cfg(0, 3, 3, 1'b1);
        op(1, 12'hE05, 16'h005A, 0, 0, 0, 0, 0, "R6");
        op(0, 0, 0, 0, 0, 5, 0, 1, "R6");
        chk16("R6", "alias of 0xE05", b_rdata, 16'h005A);

        // R7: read enable low holds output
        op(1, 5, 16'h0033, 0, 0, 5, 0, 0, "R7");
        chk16("R7", "b_rdata held", b_rdata, 16'h005A);

        // R8: write enable low writes nothing
        op(0, 5, 16'h0077, 0, 0, 0, 0, 0, "R8");
        op(0, 0, 0, 0, 0, 5, 0, 1, "R8");
        chk16("R8", "no write", b_rdata, 16'h0033);

        // R10: change in RUN goes through CHECK
        cfg_mode = 2'd0; cfg_wa = 3'd1; cfg_wb = 3'd2;
        cur_mode = 0; cur_wa = 1; cur_wb = 2; cur_legal = 1'b0;
        @(negedge clk);
        chk16("R10", "cfg_ok in CHECK", 16'(cfg_ok), 16'd0);
        chk16("R10", "cfg_err in CHECK", 16'(cfg_err), 16'd0);
        @(negedge clk);
        chk16("R10", "cfg_err after CHECK", 16'(cfg_err), 16'd1);
        set_cfg(0, 3, 3, 1'b1);
        chk16("R10", "cfg_ok restored", 16'(cfg_ok), 16'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule